// File: doc/BRIEF.md
# AUX Request Packet Formatter

This block turns one DisplayPort AUX channel request into the byte stream that a channel transmitter sends, and then interprets the reply that comes back. The requester pulses a start strobe and supplies a 4-bit request command, a 20-bit address, a payload length and up to `MAX_LEN` write bytes. The block checks the request and builds a four-byte header. It then streams the header, followed by the payload for writes, one byte per cycle over a valid/ready handshake.

When the transmitter has taken the last byte, the block waits for a reply status and a returned-byte count. It classifies the status into an error code. For a successful read, it passes the returned bytes on to the requester, keeping no more bytes than were asked for. Line coding, sync patterns, the physical transceiver and retry policy are handled elsewhere.

Top module: `aux_req_fmt`

## Requirements
- R1: Header byte 0 is address bits 7:0, and header byte 1 is address bits 15:8. Header byte 2 has the command in bits 7:4 and address bits 19:16 in bits 3:0. Byte 0 is sent first.
- R2: The low nibble of header byte 3 is the payload length minus one, or 0 when the length is 0.
- R3: The high nibble of header byte 3 is 3 for a zero-length request. Otherwise it is 4 for a read, and the low four bits of 4 plus the length for a write, so that length 12 gives 0 and length 16 gives 4.
- R4: A write sends the header and then the payload bytes in index order, where payload byte i is `wdata_i[8i+7:8i]`, captured at start. A read sends only the four header bytes.
- R5: A byte on the transmit stream stays unchanged while `tx_valid_o` is high and `tx_ready_i` is low. Each cycle with both high moves the stream to the next byte.
- R6: A start with a length above `MAX_LEN` is rejected in the next cycle with `done_o` high and error code 1 (too big). No byte is sent and `busy_o` stays low. This check takes precedence over the command check.
- R7: A command is accepted when its bit 1 is 0; bit 2 (middle-of-transaction) is ignored, and bit 0 set means read. Any command with bit 1 set is rejected in the next cycle with error code 2, and no byte is sent.
- R8: A reply status of exactly 1, 2 or 3 ends the request with error code 3 (timeout), 4 (flags non-zero) or 5 (channel error) respectively. Reply code and count are then reported as 0.
- R9: Any other reply status ends the request with error code 0 and a reply code equal to status bits 7:4.
- R10: A successful write reports its payload length as the transfer count.
- R11: A successful read reports min(returned count, requested length). Only the first that many returned bytes appear on `rd_valid_o`/`rd_data_o`, in the same cycle they arrive. Completion comes after all returned bytes have been consumed, or at the reply when the returned count is 0.
- R12: `busy_o` is high from the cycle after an accepted start until completion. A start while busy is ignored. `done_o` is a one-cycle pulse in the cycle after the ending edge, and `err_o`, `reply_o` and `xfer_cnt_o` hold their values from then on.
- R13: During and right after reset, `busy_o`, `tx_valid_o` and `done_o` are low and `err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe |
| cmd_i | input | 4 | Request command |
| addr_i | input | 20 | Request address |
| len_i | input | LEN_W (6) | Payload length in bytes |
| wdata_i | input | MAX_LEN*8 (128) | Write payload, byte i at bits 8i+7:8i |
| busy_o | output | 1 | Request in progress |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_data_o | output | 8 | Transmit byte |
| tx_ready_i | input | 1 | Transmitter accepts byte |
| rply_valid_i | input | 1 | Reply status present |
| rply_status_i | input | 8 | Reply status byte |
| rply_count_i | input | LEN_W (6) | Number of bytes the reply returns |
| rx_valid_i | input | 1 | Returned byte present |
| rx_data_i | input | 8 | Returned byte |
| rd_valid_o | output | 1 | Read byte delivered to the requester |
| rd_data_o | output | 8 | Read byte |
| done_o | output | 1 | Request finished (one-cycle pulse) |
| err_o | output | 3 | Error code |
| reply_o | output | 4 | Reply code |
| xfer_cnt_o | output | LEN_W (6) | Bytes transferred |

## Verification
The bench builds the block with `MAX_LEN` = 16, which makes the length port 6 bits wide. That brings the largest legal payload (16 bytes, whose write size nibble wraps to 4) and the smallest rejected one (17) within reach. With 16 payload bytes the bench can also return 20 read bytes, so clamping drops four of them. A 12-byte write makes the size nibble wrap to 0, and lengths 0, 2, 3, 4 and 8 cover the bare-address request, partial returns and stalled streams.

// File: rtl/aux_fmt_pkg.sv
package aux_fmt_pkg;
  localparam int ADDR_BITS = 20;
  localparam int HDR_BYTES = 4;

  // reply status values that abort a request
  localparam logic [7:0] RS_TIMEOUT = 8'd1;
  localparam logic [7:0] RS_FLAGS   = 8'd2;
  localparam logic [7:0] RS_LINKERR = 8'd3;

  typedef enum logic [2:0] {
    XE_NONE    = 3'd0,
    XE_TOOBIG  = 3'd1,
    XE_BADCMD  = 3'd2,
    XE_TIMEOUT = 3'd3,
    XE_FLAGS   = 3'd4,
    XE_LINKERR = 3'd5
  } xfer_err_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_RECV
  } seq_state_e;
endpackage

// File: rtl/aux_hdr_pack.sv
module aux_hdr_pack
  import aux_fmt_pkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = 6
) (
  input  logic [3:0]             cmd_i,
  input  logic [ADDR_BITS-1:0]   addr_i,
  input  logic [LEN_W-1:0]       len_i,
  output logic [HDR_BYTES*8-1:0] hdr_o,
  output logic                   is_read_o,
  output logic                   cmd_ok_o,
  output logic                   too_big_o
);
  logic [LEN_W-1:0] len_m1;
  logic [LEN_W:0]   wr_total;
  logic [3:0]       len_nib;
  logic [3:0]       size_nib;

  always_comb begin
    len_m1    = len_i - 1'b1;
    wr_total  = {1'b0, len_i} + (LEN_W+1)'(HDR_BYTES);
    is_read_o = cmd_i[0];
    // bit 2 (middle of transaction) does not matter, bit 1 must be clear
    cmd_ok_o  = ~cmd_i[1];
    too_big_o = len_i > LEN_W'(MAX_LEN);
    len_nib   = (len_i == '0) ? 4'h0 : len_m1[3:0];
    if (len_i == '0)     size_nib = 4'd3;
    else if (cmd_i[0])   size_nib = 4'(HDR_BYTES);
    else                 size_nib = wr_total[3:0];
    hdr_o = {size_nib, len_nib, cmd_i, addr_i[19:16], addr_i[15:8], addr_i[7:0]};
  end
endmodule

// File: rtl/aux_tx_seq.sv
module aux_tx_seq
  import aux_fmt_pkg::*;
#(
  parameter int MAX_LEN = 16,
  localparam int TOT_MAX = HDR_BYTES + MAX_LEN,
  localparam int IDX_W   = $clog2(TOT_MAX + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_i,
  input  logic [HDR_BYTES*8-1:0] hdr_i,
  input  logic [MAX_LEN*8-1:0]   pay_i,
  input  logic [IDX_W-1:0]       nbytes_i,
  output logic                   tx_valid_o,
  output logic [7:0]             tx_data_o,
  input  logic                   tx_ready_i,
  output logic                   last_o
);
  logic [TOT_MAX*8-1:0] buf_q;
  logic                 act_q, act_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [IDX_W-1:0]     cnt_q, cnt_d;
  logic                 at_end;

  assign at_end     = (idx_q == cnt_q - 1'b1);
  assign tx_valid_o = act_q;
  assign tx_data_o  = act_q ? buf_q[{idx_q, 3'b000} +: 8] : 8'h00;
  assign last_o     = act_q && tx_ready_i && at_end;

  always_comb begin
    act_d = act_q;
    idx_d = idx_q;
    cnt_d = cnt_q;
    if (load_i) begin
      act_d = 1'b1;
      idx_d = '0;
      cnt_d = nbytes_i;
    end else if (act_q && tx_ready_i) begin
      idx_d = idx_q + 1'b1;
      if (at_end) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      idx_q <= idx_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_i) buf_q <= {pay_i, hdr_i};
  end

  assert_hold_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));
endmodule

// File: rtl/aux_rx_collect.sv
module aux_rx_collect #(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic [LEN_W-1:0] total_i,
  input  logic [LEN_W-1:0] limit_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_data_i,
  output logic             rd_valid_o,
  output logic [7:0]       rd_data_o,
  output logic             last_o
);
  logic             act_q, act_d;
  logic [LEN_W-1:0] left_q, left_d;
  logic [LEN_W-1:0] pos_q, pos_d;
  logic [LEN_W-1:0] lim_q, lim_d;
  logic             take;

  assign take       = act_q && rx_valid_i;
  assign last_o     = take && (left_q == LEN_W'(1));
  assign rd_valid_o = take && (pos_q < lim_q);
  assign rd_data_o  = rx_data_i;

  always_comb begin
    act_d  = act_q;
    left_d = left_q;
    pos_d  = pos_q;
    lim_d  = lim_q;
    if (arm_i) begin
      act_d  = 1'b1;
      left_d = total_i;
      pos_d  = '0;
      lim_d  = limit_i;
    end else if (take) begin
      left_d = left_q - 1'b1;
      pos_d  = pos_q + 1'b1;
      if (left_q == LEN_W'(1)) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      left_q <= '0;
      pos_q  <= '0;
      lim_q  <= '0;
    end else begin
      act_q  <= act_d;
      left_q <= left_d;
      pos_q  <= pos_d;
      lim_q  <= lim_d;
    end
  end
endmodule

// File: rtl/aux_req_fmt.sv
module aux_req_fmt
  import aux_fmt_pkg::*;
#(
  parameter int MAX_LEN = 16,
  localparam int LEN_W = $clog2(MAX_LEN + 1) + 1,
  localparam int IDX_W = $clog2(HDR_BYTES + MAX_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [3:0]           cmd_i,
  input  logic [ADDR_BITS-1:0] addr_i,
  input  logic [LEN_W-1:0]     len_i,
  input  logic [MAX_LEN*8-1:0] wdata_i,
  output logic                 busy_o,
  output logic                 tx_valid_o,
  output logic [7:0]           tx_data_o,
  input  logic                 tx_ready_i,
  input  logic                 rply_valid_i,
  input  logic [7:0]           rply_status_i,
  input  logic [LEN_W-1:0]     rply_count_i,
  input  logic                 rx_valid_i,
  input  logic [7:0]           rx_data_i,
  output logic                 rd_valid_o,
  output logic [7:0]           rd_data_o,
  output logic                 done_o,
  output logic [2:0]           err_o,
  output logic [3:0]           reply_o,
  output logic [LEN_W-1:0]     xfer_cnt_o
);
  logic [HDR_BYTES*8-1:0] hdr;
  logic                   is_read, cmd_ok, too_big;
  logic [IDX_W-1:0]       tx_total;
  logic                   tx_load, tx_last;
  logic                   rx_arm, rx_last;

  seq_state_e       st_q, st_d;
  logic             rd_q;
  logic [LEN_W-1:0] len_q;
  logic             done_q, done_d;
  xfer_err_e        err_q, err_d;
  logic [3:0]       rep_q, rep_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] clamp;
  logic             aborted;

  aux_hdr_pack #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_hdr (
    .cmd_i     (cmd_i),
    .addr_i    (addr_i),
    .len_i     (len_i),
    .hdr_o     (hdr),
    .is_read_o (is_read),
    .cmd_ok_o  (cmd_ok),
    .too_big_o (too_big)
  );

  assign tx_total = is_read ? IDX_W'(HDR_BYTES) : IDX_W'(HDR_BYTES) + IDX_W'(len_i);

  aux_tx_seq #(.MAX_LEN(MAX_LEN)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tx_load),
    .hdr_i      (hdr),
    .pay_i      (wdata_i),
    .nbytes_i   (tx_total),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o),
    .tx_ready_i (tx_ready_i),
    .last_o     (tx_last)
  );

  aux_rx_collect #(.LEN_W(LEN_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_i      (rx_arm),
    .total_i    (rply_count_i),
    .limit_i    (len_q),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o),
    .last_o     (rx_last)
  );

  always_comb begin
    st_d    = st_q;
    done_d  = 1'b0;
    err_d   = err_q;
    rep_d   = rep_q;
    cnt_d   = cnt_q;
    tx_load = 1'b0;
    rx_arm  = 1'b0;
    aborted = 1'b0;
    clamp   = (rply_count_i < len_q) ? rply_count_i : len_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          if (too_big || !cmd_ok) begin
            done_d = 1'b1;
            err_d  = too_big ? XE_TOOBIG : XE_BADCMD;
            rep_d  = '0;
            cnt_d  = '0;
          end else begin
            st_d    = ST_SEND;
            tx_load = 1'b1;
          end
        end
      end
      ST_SEND: begin
        if (tx_last) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (rply_valid_i) begin
          err_d = XE_NONE;
          rep_d = rply_status_i[7:4];
          cnt_d = rd_q ? clamp : len_q;
          if (rply_status_i == RS_TIMEOUT) begin
            err_d = XE_TIMEOUT; aborted = 1'b1;
          end else if (rply_status_i == RS_FLAGS) begin
            err_d = XE_FLAGS; aborted = 1'b1;
          end else if (rply_status_i == RS_LINKERR) begin
            err_d = XE_LINKERR; aborted = 1'b1;
          end
          if (aborted) begin
            rep_d = '0;
            cnt_d = '0;
          end
          if (aborted || !rd_q || rply_count_i == '0) begin
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            rx_arm = 1'b1;
            st_d   = ST_RECV;
          end
        end
      end
      ST_RECV: begin
        if (rx_last) begin
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rd_q   <= 1'b0;
      len_q  <= '0;
      done_q <= 1'b0;
      err_q  <= XE_NONE;
      rep_q  <= '0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      err_q  <= err_d;
      rep_q  <= rep_d;
      cnt_q  <= cnt_d;
      if (tx_load) begin
        rd_q  <= is_read;
        len_q <= len_i;
      end
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign reply_o    = rep_q;
  assign xfer_cnt_o = cnt_q;

  // rejected or idle requests never drive the transmit stream
  assert_quiet_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !tx_valid_o);

  assert_reject_size_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && len_i > LEN_W'(MAX_LEN))
      |=> (done_o && err_o == XE_TOOBIG && !busy_o));

  assert_reject_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && len_i <= LEN_W'(MAX_LEN) && cmd_i[1])
      |=> (done_o && err_o == XE_BADCMD && !busy_o));

  assert_clamp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && rd_q && err_o == XE_NONE) |-> (xfer_cnt_o <= len_q));

  assert_rd_in_flight_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> busy_o);

  assert_busy_from_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: tb/tb_aux_req_fmt.sv
module tb_aux_req_fmt;
  localparam int PER  = 10;
  localparam int MAXL = 16;
  localparam int LW   = $clog2(MAXL + 1) + 1;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            start_i;
  logic [3:0]      cmd_i;
  logic [19:0]     addr_i;
  logic [LW-1:0]   len_i;
  logic [MAXL*8-1:0] wdata_i;
  logic            busy_o;
  logic            tx_valid_o;
  logic [7:0]      tx_data_o;
  logic            tx_ready_i;
  logic            rply_valid_i;
  logic [7:0]      rply_status_i;
  logic [LW-1:0]   rply_count_i;
  logic            rx_valid_i;
  logic [7:0]      rx_data_i;
  logic            rd_valid_o;
  logic [7:0]      rd_data_o;
  logic            done_o;
  logic [2:0]      err_o;
  logic [3:0]      reply_o;
  logic [LW-1:0]   xfer_cnt_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit in_reset = 1'b1;
  bit stall    = 1'b0;
  bit exp_busy = 1'b0;
  bit exp_done = 1'b0;
  byte unsigned exp_q[$];
  string        tag_q[$];
  logic [MAXL*8-1:0] pat;

  aux_req_fmt #(.MAX_LEN(MAXL)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i), .addr_i(addr_i),
    .len_i(len_i), .wdata_i(wdata_i), .busy_o(busy_o), .tx_valid_o(tx_valid_o),
    .tx_data_o(tx_data_o), .tx_ready_i(tx_ready_i), .rply_valid_i(rply_valid_i),
    .rply_status_i(rply_status_i), .rply_count_i(rply_count_i), .rx_valid_i(rx_valid_i),
    .rx_data_i(rx_data_i), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .done_o(done_o), .err_o(err_o), .reply_o(reply_o), .xfer_cnt_o(xfer_cnt_o)
  );

  always #(PER/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  // transmitter back-pressure, changed just after the falling edge
  always @(negedge clk) begin
    #1;
    tx_ready_i = stall ? ((cyc % 3) != 1) : 1'b1;
  end

  // per-clock comparison against the behavioural model, one unit before the rising edge
  always begin
    @(negedge clk);
    #(PER/2 - 1);
    if (!in_reset) begin
      chk(busy_o === exp_busy, "R12 busy", busy_o, exp_busy);
      chk(done_o === exp_done, "R12 done", done_o, exp_done);
      chk(tx_valid_o === (exp_q.size() != 0), "R5 valid", tx_valid_o, exp_q.size() != 0);
      if (tx_valid_o && exp_q.size() != 0) begin
        chk(tx_data_o === exp_q[0], tag_q[0], tx_data_o, exp_q[0]);
        if (tx_ready_i) begin
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end
      end
    end
  end

  task automatic expect_end(input int e_err, input int e_rep, input int e_cnt, input string tag);
    exp_done = 1'b1;
    exp_busy = 1'b0;
    chk(err_o == 3'(e_err), {tag, " err"}, err_o, e_err);
    chk(reply_o == 4'(e_rep), "R9 reply", reply_o, e_rep);
    chk(xfer_cnt_o == LW'(e_cnt), {tag, " count"}, xfer_cnt_o, e_cnt);
    tick();
    exp_done = 1'b0;
  endtask

  task automatic run_req(input logic [3:0] cmd, input logic [19:0] addr, input int len,
                         input logic [7:0] stat, input int rcnt, input bit poke);
    bit rd;
    int sz, b3, e_err, e_rep, e_cnt, kept;
    rd = cmd[0];
    tick();
    start_i = 1'b1; cmd_i = cmd; addr_i = addr; len_i = LW'(len); wdata_i = pat;
    tick();
    start_i = 1'b0; cmd_i = 4'h2; addr_i = '0; len_i = '0; wdata_i = '0;
    if (len > MAXL) begin
      chk(tx_valid_o == 1'b0, "R6 nothing sent", tx_valid_o, 0);
      expect_end(1, 0, 0, "R6");
      return;
    end
    if (cmd[1]) begin
      chk(tx_valid_o == 1'b0, "R7 nothing sent", tx_valid_o, 0);
      expect_end(2, 0, 0, "R7");
      return;
    end
    exp_busy = 1'b1;
    sz = (len == 0) ? 3 : (rd ? 4 : 4 + len);
    b3 = ((sz & 15) << 4) | ((len == 0) ? 0 : ((len - 1) & 15));
    exp_q.push_back(addr[7:0]);           tag_q.push_back("R1 byte0");
    exp_q.push_back(addr[15:8]);          tag_q.push_back("R1 byte1");
    exp_q.push_back({cmd, addr[19:16]});  tag_q.push_back("R1 byte2");
    exp_q.push_back(8'(b3));              tag_q.push_back("R2/R3 byte3");
    if (!rd)
      for (int i = 0; i < len; i++) begin
        exp_q.push_back(pat[8*i +: 8]);
        tag_q.push_back("R4 payload");
      end
    if (poke) begin
      // R12: a second start while busy must not disturb the stream
      tick();
      start_i = 1'b1; cmd_i = 4'h9; addr_i = 20'hFFFFF; len_i = LW'(1);
      tick();
      start_i = 1'b0; cmd_i = 4'h2; addr_i = '0; len_i = '0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    #1;
    rply_valid_i = 1'b1; rply_status_i = stat; rply_count_i = LW'(rcnt);
    tick();
    rply_valid_i = 1'b0; rply_status_i = '0; rply_count_i = '0;
    kept = (rcnt < len) ? rcnt : len;
    if (stat >= 8'd1 && stat <= 8'd3) begin
      e_err = stat + 2; e_rep = 0; e_cnt = 0;
      expect_end(e_err, e_rep, e_cnt, "R8");
      return;
    end
    e_rep = stat >> 4;
    if (!rd) begin
      expect_end(0, e_rep, len, "R10");
      return;
    end
    if (rcnt == 0) begin
      expect_end(0, e_rep, 0, "R11");
      return;
    end
    for (int k = 0; k < rcnt; k++) begin
      if (k == 1) begin
        rx_valid_i = 1'b0;
        tick();
      end
      rx_valid_i = 1'b1;
      rx_data_i  = 8'hA0 + 8'(k);
      #1;
      chk(rd_valid_o == (k < kept), "R11 forward", rd_valid_o, k < kept);
      if (k < kept) chk(rd_data_o == 8'hA0 + 8'(k), "R11 data", rd_data_o, 8'hA0 + k);
      tick();
    end
    rx_valid_i = 1'b0;
    expect_end(0, e_rep, kept, "R11");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R12 watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < MAXL; i++) pat[8*i +: 8] = 8'(i * 17 + 3);
    rst_n = 1'b0; start_i = 1'b0; cmd_i = '0; addr_i = '0; len_i = '0; wdata_i = '0;
    rply_valid_i = 1'b0; rply_status_i = '0; rply_count_i = '0;
    rx_valid_i = 1'b0; rx_data_i = '0; tx_ready_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0, "R13 busy", busy_o, 0);
    chk(tx_valid_o == 1'b0, "R13 tx_valid", tx_valid_o, 0);
    chk(done_o == 1'b0, "R13 done", done_o, 0);
    chk(err_o == 3'd0, "R13 err", err_o, 0);
    #1;
    rst_n = 1'b1;
    in_reset = 1'b0;
    tick();
    chk(busy_o == 1'b0 && done_o == 1'b0, "R13 after release", {busy_o, done_o}, 0);

    run_req(4'h8, 20'h5A3C7, 3, 8'h00, 0, 1'b0);    // native write
    stall = 1'b1;
    run_req(4'h5, 20'hABCDE, 16, 8'h00, 20, 1'b0);  // I2C read with MOT, 20 returned, keep 16
    run_req(4'hC, 20'h12345, 16, 8'h10, 0, 1'b1);   // 16-byte write, size nibble wraps to 4
    stall = 1'b0;
    run_req(4'h9, 20'h00010, 0, 8'h00, 0, 1'b0);    // bare-address read
    run_req(4'h0, 20'hF0F0F, 0, 8'h20, 0, 1'b0);    // bare-address write
    run_req(4'h1, 20'h00400, 4, 8'h00, 2, 1'b0);    // short return
    run_req(4'h4, 20'h00001, 12, 8'h00, 0, 1'b0);   // size nibble wraps to 0
    run_req(4'h8, 20'h00002, 17, 8'h00, 0, 1'b0);   // too big
    run_req(4'hA, 20'h00003, 17, 8'h00, 0, 1'b0);   // too big wins over bad command
    run_req(4'hB, 20'h00004, 1, 8'h00, 0, 1'b0);    // bad command
    run_req(4'h2, 20'h00005, 0, 8'h00, 0, 1'b0);    // bad command, zero length
    run_req(4'h9, 20'h00006, 2, 8'h01, 2, 1'b0);    // timeout
    run_req(4'h8, 20'h00007, 1, 8'h02, 0, 1'b0);    // flags non-zero
    run_req(4'h1, 20'h00008, 3, 8'h03, 3, 1'b0);    // channel error
    stall = 1'b1;
    run_req(4'h8, 20'h9C0DE, 8, 8'h00, 0, 1'b1);    // stalled write with ignored start
    stall = 1'b0;
    repeat (3) tick();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule